// File: doc/BRIEF.md
# Four-Span Timeslot Buffer with Serial Shifters

This block sits between a host that moves 32-bit words and four serial framer streams. The host sees two word arrays at the same word addresses. Writes fill the outgoing (transmit) array and reads return the incoming (receive) array. Word address N holds timeslot N of the frame for all four spans at once, one byte per span.

On the serial side, one common bit strobe and one frame marker pace all four spans together. Each span has a transmit shifter that sends its byte MSB first. A receive shifter collects eight bits and then drops the byte into its lane of the current timeslot word. A mode input picks a 24-slot frame or a 32-slot frame.

Two loopbacks are offered. The local buffer loopback fills the receive array from the bytes being transmitted. The remote serial loopback sends each span's incoming serial bit straight back out on its transmit pin. The host and serial sides use separate ports of the storage, so host traffic never holds up the serial timing.

Top module: `span_buf_serial`

## Requirements
- R1: A host write with `host_we` high stores `host_wdata` into transmit word `host_addr`. A host read returns receive word `host_addr` on `host_rdata` one clock later, from a register.
- R2: Span index 0 uses word bits 31:24, span 1 uses bits 23:16, span 2 uses bits 15:8 and span 3 uses bits 7:0, in both arrays.
- R3: The word address equals the timeslot number, so timeslot N of a frame is read from and written to word N.
- R4: Each transmit byte is sent MSB first, one bit per strobe. The bit for a strobe appears on `ser_tx` after the clock edge that takes the strobe, and it is held until the next strobe.
- R5: A strobe that has `ser_fsync` high is bit 0 of timeslot 0, whatever the counters held before.
- R6: With `mode_e1` low a frame has 24 timeslots, and receive words 24 to 31 are never written. With `mode_e1` high a frame has 32 timeslots. After the last bit of the last timeslot the count returns to timeslot 0.
- R7: A received byte is written into its lane of the current word only on the strobe that carries its eighth bit. Before that strobe the word keeps its old value.
- R8: The byte for timeslot N is fetched from the transmit array at the last bit of timeslot N-1. A host write to word N after that fetch has no effect until the next frame. A write made before the fetch is sent in the same frame.
- R9: With `lb_local` high, each timeslot's receive word takes the byte transmitted in that timeslot, and the `ser_rx` pins are ignored.
- R10: With `lb_remote` high, every `ser_tx` pin carries the level on the matching `ser_rx` pin.
- R11: After reset, `ser_tx` is all zero, `host_rdata` is zero and every receive word reads as zero.
- R12: While `ser_bit_en` is low the bit and slot counters and the transmit pins hold their values. Host reads work throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host and serial logic |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe into the transmit array |
| host_addr | input | CH_W (5) | Word address, equal to the timeslot number |
| host_wdata | input | N_SPAN*BYTE_W (32) | Word to store, one byte per span |
| host_rdata | output | N_SPAN*BYTE_W (32) | Registered receive word |
| ser_bit_en | input | 1 | One-cycle strobe per serial bit period |
| ser_fsync | input | 1 | Frame marker, sampled only with a strobe |
| mode_e1 | input | 1 | 1 selects the 32-slot frame, 0 selects the 24-slot frame |
| lb_local | input | 1 | Receive array fed from transmitted bytes |
| lb_remote | input | 1 | Transmit pins driven from receive pins |
| ser_rx | input | N_SPAN (4) | Serial receive data, bit i for span i |
| ser_tx | output | N_SPAN (4) | Serial transmit data, bit i for span i |

## Verification
The bench uses the default parameters: four 8-bit spans, 24- and 32-slot frames, and a 5-bit word address. With these values both frame lengths fit in the 32-word arrays, and the eight upper words that a 24-slot frame never writes can be checked. Distinct per-lane byte patterns show the lane order. A host write placed mid-frame on either side of a prefetch shows when the transmit fetch takes effect.

// File: rtl/sbsi_pkg.sv
package sbsi_pkg;

  // Bit offset of a span's byte lane: span 0 takes the top lane.
  function automatic int unsigned lane_lsb(input int unsigned span,
                                           input int unsigned nspan,
                                           input int unsigned bw);
    return (nspan - 1 - span) * bw;
  endfunction

  // Index of the last timeslot in a frame for the selected mode.
  function automatic int unsigned last_slot(input logic e1,
                                            input int unsigned t1n,
                                            input int unsigned e1n);
    return e1 ? (e1n - 1) : (t1n - 1);
  endfunction

endpackage

// File: rtl/sbsi_timing.sv
module sbsi_timing #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned T1_SLOTS = 24,
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned CH_W     = 5,
  parameter int unsigned BIT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  input  logic             e1,
  output logic [BIT_W-1:0] cur_pos,
  output logic [CH_W-1:0]  cur_ch,
  output logic [CH_W-1:0]  nxt_ch,
  output logic [BIT_W-1:0] pos_q,
  output logic [CH_W-1:0]  chan_q,
  output logic             slot_start,
  output logic             slot_end
);
  logic [CH_W-1:0] last;
  logic            at_last_bit;

  always_comb begin
    last        = CH_W'(sbsi_pkg::last_slot(e1, T1_SLOTS, E1_SLOTS));
    cur_pos     = fsync ? '0 : pos_q;
    cur_ch      = fsync ? '0 : chan_q;
    nxt_ch      = (cur_ch >= last) ? '0 : cur_ch + 1'b1;
    at_last_bit = (cur_pos == BIT_W'(BYTE_W - 1));
    slot_start  = bit_en && (cur_pos == '0);
    slot_end    = bit_en && at_last_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      chan_q <= '0;
    end else if (bit_en) begin
      pos_q  <= at_last_bit ? '0 : cur_pos + 1'b1;
      chan_q <= at_last_bit ? nxt_ch : cur_ch;
    end
  end
endmodule

// File: rtl/sbsi_lane.sv
module sbsi_lane #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              slot_start,
  input  logic              slot_end,
  input  logic              loc_lb,
  input  logic              rem_lb,
  input  logic              rx_pin,
  input  logic [BYTE_W-1:0] pref_in,
  output logic              tx_pin,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              pref_msb
);
  logic [BYTE_W-1:0] pref_q;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] tx_cur;
  logic [BYTE_W-2:0] rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pref_q <= '0;
      tx_sh  <= '0;
      tx_cur <= '0;
      rx_sh  <= '0;
    end else begin
      if (slot_end) pref_q <= pref_in;
      if (slot_start) begin
        tx_sh  <= pref_q;
        tx_cur <= pref_q;
      end else if (bit_en) begin
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
      if (bit_en) rx_sh <= {rx_sh[BYTE_W-3:0], rx_pin};
    end
  end

  assign tx_pin   = rem_lb ? rx_pin : tx_sh[BYTE_W-1];
  assign rx_byte  = loc_lb ? tx_cur : {rx_sh, rx_pin};
  assign pref_msb = pref_q[BYTE_W-1];
endmodule

// File: rtl/sbsi_buf.sv
module sbsi_buf #(
  parameter int unsigned CH_W   = 5,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [CH_W-1:0]   h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  output logic [WORD_W-1:0] h_rdata,
  input  logic [CH_W-1:0]   s_raddr,
  output logic [WORD_W-1:0] s_rdata,
  input  logic              s_we,
  input  logic [CH_W-1:0]   s_waddr,
  input  logic [WORD_W-1:0] s_wdata
);
  localparam int unsigned DEPTH = 1 << CH_W;

  logic [WORD_W-1:0] tx_mem [DEPTH];
  logic [WORD_W-1:0] rx_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tx_mem[i] <= '0;
        rx_mem[i] <= '0;
      end
      h_rdata <= '0;
    end else begin
      if (h_we) tx_mem[h_addr] <= h_wdata;
      if (s_we) rx_mem[s_waddr] <= s_wdata;
      h_rdata <= rx_mem[h_addr];
    end
  end

  assign s_rdata = tx_mem[s_raddr];
endmodule

// File: rtl/span_buf_serial.sv
module span_buf_serial #(
  parameter int unsigned N_SPAN   = 4,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned T1_SLOTS = 24,
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned CH_W     = $clog2(E1_SLOTS),
  parameter int unsigned WORD_W   = N_SPAN * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [CH_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              ser_bit_en,
  input  logic              ser_fsync,
  input  logic              mode_e1,
  input  logic              lb_local,
  input  logic              lb_remote,
  input  logic [N_SPAN-1:0] ser_rx,
  output logic [N_SPAN-1:0] ser_tx
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic [BIT_W-1:0]  cur_pos;
  logic [CH_W-1:0]   cur_ch;
  logic [CH_W-1:0]   nxt_ch;
  logic [BIT_W-1:0]  pos_q;
  logic [CH_W-1:0]   chan_q;
  logic              slot_start;
  logic              slot_end;
  logic              rx_we;
  logic [WORD_W-1:0] tx_rd_word;
  logic [WORD_W-1:0] rx_wr_word;
  logic [N_SPAN-1:0] pref_msb;

  sbsi_timing #(
    .BYTE_W(BYTE_W), .T1_SLOTS(T1_SLOTS), .E1_SLOTS(E1_SLOTS),
    .CH_W(CH_W), .BIT_W(BIT_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .bit_en(ser_bit_en), .fsync(ser_fsync),
    .e1(mode_e1), .cur_pos(cur_pos), .cur_ch(cur_ch), .nxt_ch(nxt_ch),
    .pos_q(pos_q), .chan_q(chan_q), .slot_start(slot_start),
    .slot_end(slot_end)
  );

  assign rx_we = slot_end;

  for (genvar s = 0; s < N_SPAN; s++) begin : g_lane
    localparam int unsigned LSB = sbsi_pkg::lane_lsb(s, N_SPAN, BYTE_W);
    sbsi_lane #(.BYTE_W(BYTE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .bit_en(ser_bit_en),
      .slot_start(slot_start), .slot_end(slot_end),
      .loc_lb(lb_local), .rem_lb(lb_remote), .rx_pin(ser_rx[s]),
      .pref_in(tx_rd_word[LSB +: BYTE_W]), .tx_pin(ser_tx[s]),
      .rx_byte(rx_wr_word[LSB +: BYTE_W]), .pref_msb(pref_msb[s])
    );
  end

  sbsi_buf #(.CH_W(CH_W), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata),
    .h_rdata(host_rdata),
    .s_raddr(nxt_ch), .s_rdata(tx_rd_word),
    .s_we(rx_we), .s_waddr(cur_ch), .s_wdata(rx_wr_word)
  );
endmodule

// File: rtl/span_buf_serial_chk.sv
module span_buf_serial_chk #(
  parameter int unsigned N_SPAN   = 4,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned T1_SLOTS = 24,
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned CH_W     = 5,
  parameter int unsigned BIT_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_bit_en,
  input logic              ser_fsync,
  input logic              mode_e1,
  input logic              lb_remote,
  input logic [BIT_W-1:0]  cur_pos,
  input logic [BIT_W-1:0]  pos_q,
  input logic [CH_W-1:0]   chan_q,
  input logic              slot_start,
  input logic              rx_we,
  input logic [N_SPAN-1:0] pref_msb,
  input logic [N_SPAN-1:0] ser_tx
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  logic [CH_W-1:0] last_ch;
  assign last_ch = mode_e1 ? CH_W'(E1_SLOTS - 1) : CH_W'(T1_SLOTS - 1);

  // R7: a receive word is stored only on the eighth bit of its slot
  p_rx_word_on_last_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (ser_bit_en && cur_pos == LAST_BIT));

  // R5: a strobe with the frame marker restarts at slot 0, next bit 1
  p_fsync_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_bit_en && ser_fsync) |=> (chan_q == '0 && pos_q == BIT_W'(1)));

  // R12: no strobe, no counter movement
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_bit_en |=> ($stable(chan_q) && $stable(pos_q)));

  // R6: the last bit of the last slot wraps to slot 0
  p_chan_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_bit_en && !ser_fsync && pos_q == LAST_BIT && chan_q == last_ch)
      |=> chan_q == '0);

  // R4: the first bit sent in a slot is the MSB of the prefetched byte
  p_tx_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !lb_remote) |=> (lb_remote || ser_tx == $past(pref_msb)));
endmodule

bind span_buf_serial span_buf_serial_chk #(
  .N_SPAN(N_SPAN), .BYTE_W(BYTE_W), .T1_SLOTS(T1_SLOTS),
  .E1_SLOTS(E1_SLOTS), .CH_W(CH_W), .BIT_W(BIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_bit_en(ser_bit_en), .ser_fsync(ser_fsync),
  .mode_e1(mode_e1), .lb_remote(lb_remote), .cur_pos(cur_pos),
  .pos_q(pos_q), .chan_q(chan_q), .slot_start(slot_start), .rx_we(rx_we),
  .pref_msb(pref_msb), .ser_tx(ser_tx)
);

// File: tb/span_buf_serial_bench.sv
`timescale 1ns/1ps
module span_buf_serial_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ser_bit_en = 1'b0;
  logic        ser_fsync = 1'b0;
  logic        mode_e1 = 1'b0;
  logic        lb_local = 1'b0;
  logic        lb_remote = 1'b0;
  logic [3:0]  ser_rx = '0;
  logic [3:0]  ser_tx;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] txw [32];
  logic [31:0] rxexp [32];

  always #2 clk = ~clk;

  span_buf_serial u_span_buf_serial (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ser_bit_en(ser_bit_en), .ser_fsync(ser_fsync), .mode_e1(mode_e1),
    .lb_local(lb_local), .lb_remote(lb_remote), .ser_rx(ser_rx),
    .ser_tx(ser_tx)
  );

  function automatic logic [31:0] mkword(input int sd, input int c);
    return {8'(sd + c), 8'((sd * 7) ^ c), 8'(c * 3 + sd), 8'(~(sd + 2 * c))};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    txw[a] = d;
  endtask

  task automatic host_read(input int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = 5'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic tick(input bit fs, input logic [3:0] rxb);
    @(negedge clk);
    ser_rx = rxb; ser_bit_en = 1'b1; ser_fsync = fs;
    @(negedge clk);
    ser_bit_en = 1'b0; ser_fsync = 1'b0;
  endtask

  // One full frame; tx compared per bit when chk_tx is set.
  task automatic run_frame(input int nslots, input int rseed, input bit chk_tx,
                           input string req, input int hook_slot,
                           input int hook_addr, input logic [31:0] hook_data);
    logic [31:0] fexp [32];
    logic [3:0]  rxb;
    logic [31:0] rw;
    int errs = 0;
    logic [31:0] bad_act = '0;
    logic [31:0] bad_exp = '0;
    for (int i = 0; i < 32; i++) fexp[i] = txw[i];
    for (int c = 0; c < nslots; c++) begin
      rw = mkword(rseed, c);
      for (int b = 0; b < 8; b++) begin
        for (int s = 0; s < 4; s++) rxb[s] = rw[31 - 8 * s - b];
        tick(c == 0 && b == 0, rxb);
        for (int s = 0; s < 4; s++) begin
          logic e;
          e = lb_remote ? rxb[s] : fexp[c][31 - 8 * s - b];
          if (chk_tx && ser_tx[s] !== e) begin
            if (errs == 0) begin
              bad_act = {c[15:0], 8'(b), 7'd0, ser_tx[s]};
              bad_exp = {c[15:0], 8'(b), 7'd0, e};
            end
            errs++;
          end
        end
        if (c == hook_slot && b == 2) begin
          host_write(hook_addr, hook_data);
          if (hook_addr > c) fexp[hook_addr] = hook_data;
        end
      end
      rxexp[c] = lb_local ? fexp[c] : rw;
    end
    if (chk_tx) check(errs == 0, req, bad_act, bad_exp);
  endtask

  task automatic check_rx(input int lo, input int hi, input string req);
    logic [31:0] d;
    int errs = 0;
    logic [31:0] ba = '0;
    logic [31:0] be = '0;
    for (int c = lo; c <= hi; c++) begin
      host_read(c, d);
      if (d !== rxexp[c]) begin
        if (errs == 0) begin ba = d; be = rxexp[c]; end
        errs++;
      end
    end
    check(errs == 0, req, ba, be);
  endtask

  task automatic load_tx(input int sd);
    for (int c = 0; c < 32; c++) host_write(c, mkword(sd, c));
  endtask

  task automatic t_reset();
    check(ser_tx == 4'h0, "R11 tx after reset", 32'(ser_tx), 32'h0);
    check(host_rdata == 32'h0, "R11 rdata after reset", host_rdata, 32'h0);
    for (int c = 0; c < 32; c++) rxexp[c] = 32'h0;
    check_rx(0, 31, "R11 rx words after reset");
  endtask

  task automatic t_t1();
    mode_e1 = 1'b0;
    load_tx(5);
    run_frame(24, 9, 1'b0, "", -1, 0, 0);
    run_frame(24, 11, 1'b1, "R4 R2 T1 transmit bits", -1, 0, 0);
    check_rx(0, 23, "R1 R2 R3 T1 receive words");
    check_rx(24, 31, "R6 T1 upper words untouched");
  endtask

  task automatic t_e1();
    mode_e1 = 1'b1;
    load_tx(21);
    run_frame(32, 3, 1'b0, "", -1, 0, 0);
    run_frame(32, 40, 1'b1, "R4 R6 E1 transmit bits", -1, 0, 0);
    check_rx(0, 31, "R6 R3 E1 receive words");
  endtask

  task automatic t_prefetch();
    run_frame(32, 41, 1'b1, "R8 write after fetch ignored", 3, 3, 32'hA5C3_0F81);
    run_frame(32, 42, 1'b1, "R8 write before fetch sent", 3, 6, 32'h5A3C_F018);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    logic [31:0] nw;
    logic [3:0]  rxb;
    logic [3:0]  held;
    logic [31:0] old0;
    old0 = rxexp[0];
    nw = mkword(77, 0);
    for (int b = 0; b < 7; b++) begin
      for (int s = 0; s < 4; s++) rxb[s] = nw[31 - 8 * s - b];
      tick(b == 0, rxb);
      if (b == 3) begin
        held = ser_tx;
        repeat (20) @(negedge clk);
        host_read(5, d);
        check(d === rxexp[5], "R12 host read while idle", d, rxexp[5]);
        check(ser_tx === held, "R12 tx held without strobe",
              32'(ser_tx), 32'(held));
      end
    end
    host_read(0, d);
    check(d === old0, "R7 word unchanged after 7 bits", d, old0);
    for (int s = 0; s < 4; s++) rxb[s] = nw[31 - 8 * s - 7];
    tick(1'b0, rxb);
    host_read(0, d);
    check(d === nw, "R7 word written on 8th bit", d, nw);
    rxexp[0] = nw;
    // leave the counters mid-slot, then realign with a marker
    for (int b = 0; b < 3; b++) tick(1'b0, 4'hF);
    run_frame(32, 50, 1'b0, "", -1, 0, 0);
    run_frame(32, 51, 1'b1, "R5 realign on frame marker", -1, 0, 0);
  endtask

  task automatic t_local();
    mode_e1 = 1'b0;
    lb_local = 1'b1;
    load_tx(60);
    run_frame(24, 61, 1'b0, "", -1, 0, 0);
    run_frame(24, 62, 1'b1, "R9 tx during local loopback", -1, 0, 0);
    check_rx(0, 23, "R9 receive words equal transmit");
    lb_local = 1'b0;
  endtask

  task automatic t_remote();
    lb_remote = 1'b1;
    run_frame(24, 70, 1'b1, "R10 tx follows rx pins", -1, 0, 0);
    lb_remote = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) txw[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_t1();
    t_e1();
    t_prefetch();
    t_partial();
    t_local();
    t_remote();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end
endmodule